// File: doc/BRIEF.md
# Prioritized Atomic Transfer Registers

This block holds two wrapping counters, a source counter and a sink counter, and three request inputs that change them. A fill request adds one to the source counter. A move request takes one unit off the source counter and puts it on the sink counter, and both changes land in the same clock edge. A drain request takes one off the sink counter. Either both halves of the move take effect or neither does.

Each counter accepts only one update per cycle. A fixed ranking settles conflicts: drain ranks above move, and move ranks above fill. Requests that touch different counters are granted together, so fill and drain can both proceed in a cycle where move is not granted. For each request, a grant output is high in exactly the cycles in which that request's update is applied. The block has no handshake beyond these grants. A requester that loses simply keeps its request asserted.

Top module: `atomic_xfer_regs`

## Requirements
- R1: With synchronous active-high reset asserted, at the next clock edge both counters become zero. While reset is high, all grants are low.
- R2: A granted fill request adds one to the source counter at the next edge, wrapping modulo 2^W.
- R3: A granted move request subtracts one from the source counter and adds one to the sink counter at the same edge, wrapping modulo 2^W. Neither counter ever changes by the move alone without the other.
- R4: A granted drain request subtracts one from the sink counter at the next edge, wrapping modulo 2^W.
- R5: Drain is granted whenever it is requested.
- R6: Move is granted exactly when it is requested and drain is not requested.
- R7: Fill is granted exactly when it is requested and move is not granted. In that case fill and drain may be granted in the same cycle.
- R8: A counter whose requests are all ungranted or absent keeps its value. Each grant output is combinational and valid in the same cycle as its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fillReq | input | 1 | Request to add one to the source counter |
| moveReq | input | 1 | Request to move one unit from the source counter to the sink counter |
| drainReq | input | 1 | Request to subtract one from the sink counter |
| fillGnt | output | 1 | Fill update applied this cycle |
| moveGnt | output | 1 | Move update applied this cycle |
| drainGnt | output | 1 | Drain update applied this cycle |
| srcCount | output | W | Source counter value |
| sinkCount | output | W | Sink counter value |

## Verification
The hardest situations to reach from the ports are wraparound at both ends of each counter while a move is active. Move makes the source counter underflow and the sink counter overflow in the same edge, and the bench needs that case to check that the two halves stay locked together. The bench uses a 3-bit configuration and runs all eight request combinations from every reachable counter pair. Before each step it drives the counters to the chosen pair using fill and move requests, with the arithmetic worked out in the bench. Every pair, including 0 and 7 on either side, is therefore exercised under all request patterns.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef struct packed {
    logic incSrc;
    logic decSrc;
    logic incSink;
    logic decSink;
  } xferStrobes_t;
endpackage

// File: rtl/xfer_arbiter.sv
module xfer_arbiter
  import xfer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fillReq,
  input  logic moveReq,
  input  logic drainReq,
  output logic fillGnt,
  output logic moveGnt,
  output logic drainGnt,
  output xferStrobes_t strobes
);
  always_comb begin
    drainGnt = drainReq && !rst;
    moveGnt  = moveReq && !drainReq && !rst;
    fillGnt  = fillReq && !moveGnt && !rst;
    strobes.incSrc  = fillGnt;
    strobes.decSrc  = moveGnt;
    strobes.incSink = moveGnt;
    strobes.decSink = drainGnt;
  end

  // R5: drain always wins when requested
  a_r5_drain_wins: assert property (@(posedge clk) disable iff (rst)
    drainReq |-> drainGnt);
  // R6: move blocked only by drain
  a_r6_move_blocked: assert property (@(posedge clk) disable iff (rst)
    (moveReq && !drainGnt) |-> moveGnt);
  // R7: fill and move never both granted
  a_r7_fill_excl: assert property (@(posedge clk) disable iff (rst)
    !(fillGnt && moveGnt));
  // R3: source decrement and sink increment come as a pair
  a_r3_pair: assert property (@(posedge clk) disable iff (rst)
    strobes.decSrc == strobes.incSink);
endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  xferStrobes_t strobes,
  output logic [W-1:0] srcCount,
  output logic [W-1:0] sinkCount
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] srcNext, sinkNext;

  always_comb begin
    srcNext = srcCount;
    if (strobes.incSrc && !strobes.decSrc) srcNext = srcCount + ONE;
    else if (strobes.decSrc && !strobes.incSrc) srcNext = srcCount - ONE;
    sinkNext = sinkCount;
    if (strobes.incSink && !strobes.decSink) sinkNext = sinkCount + ONE;
    else if (strobes.decSink && !strobes.incSink) sinkNext = sinkCount - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srcCount  <= '0;
      sinkCount <= '0;
    end else begin
      srcCount  <= srcNext;
      sinkCount <= sinkNext;
    end
  end

  logic pastValid;
  always_ff @(posedge clk) pastValid <= !rst;

  // R3: a move step changes both counters by one in opposite directions
  a_r3_atomic_move: assert property (@(posedge clk) disable iff (rst || !pastValid)
    $past(strobes.decSrc) && !$past(rst) |->
      (srcCount == $past(srcCount) - ONE) && (sinkCount == $past(sinkCount) + ONE));
  // R8: no strobe means the counter holds
  a_r8_src_hold: assert property (@(posedge clk) disable iff (rst || !pastValid)
    (!$past(strobes.incSrc) && !$past(strobes.decSrc) && !$past(rst)) |-> $stable(srcCount));
endmodule

// File: rtl/atomic_xfer_regs.sv
module atomic_xfer_regs
  import xfer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fillReq,
  input  logic moveReq,
  input  logic drainReq,
  output logic fillGnt,
  output logic moveGnt,
  output logic drainGnt,
  output logic [W-1:0] srcCount,
  output logic [W-1:0] sinkCount
);
  xferStrobes_t strobes;

  xfer_arbiter uArb (
    .clk(clk), .rst(rst),
    .fillReq(fillReq), .moveReq(moveReq), .drainReq(drainReq),
    .fillGnt(fillGnt), .moveGnt(moveGnt), .drainGnt(drainGnt),
    .strobes(strobes)
  );

  xfer_datapath #(.W(W)) uDp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .srcCount(srcCount), .sinkCount(sinkCount)
  );
endmodule

// File: tb/atomic_xfer_regs_test.sv
module atomic_xfer_regs_test;
  localparam int W = 3;
  localparam int M = 1 << W;

  logic clk = 0;
  logic rst = 1;
  logic fillReq = 0, moveReq = 0, drainReq = 0;
  logic fillGnt, moveGnt, drainGnt;
  logic [W-1:0] srcCount, sinkCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  atomic_xfer_regs #(.W(W)) uut (
    .clk(clk), .rst(rst),
    .fillReq(fillReq), .moveReq(moveReq), .drainReq(drainReq),
    .fillGnt(fillGnt), .moveGnt(moveGnt), .drainGnt(drainGnt),
    .srcCount(srcCount), .sinkCount(sinkCount)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic f, logic m, logic d);
    fillReq = f; moveReq = m; drainReq = d;
    @(posedge clk); #1;
    fillReq = 0; moveReq = 0; drainReq = 0;
  endtask

  task automatic doReset();
    rst = 1;
    @(posedge clk); #1;
    check("R1 gnt during reset", {fillGnt, moveGnt, drainGnt}, 0);
    rst = 0;
  endtask

  // reach (s,k): fill s+k times then move k times
  task automatic reach(int s, int k);
    doReset();
    for (int i = 0; i < s + k; i++) step(1, 0, 0);
    for (int i = 0; i < k; i++) step(0, 1, 0);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    check("R1 gnt in reset", {fillGnt, moveGnt, drainGnt}, 0);
    @(posedge clk); #1;
    check("R1 src reset", srcCount, 0);
    check("R1 sink reset", sinkCount, 0);
    rst = 0;
    for (int s = 0; s < M; s++)
      for (int k = 0; k < M; k++)
        for (int p = 0; p < 8; p++) begin
          logic f, m, d, eD, eM, eF;
          int es, ek;
          f = p[0]; m = p[1]; d = p[2];
          reach(s, k);
          check("R8 src setup", srcCount, s);
          check("R8 sink setup", sinkCount, k);
          eD = d; eM = m && !d; eF = f && !eM;
          fillReq = f; moveReq = m; drainReq = d;
          #1;
          check("R5 drainGnt", drainGnt, eD);
          check("R6 moveGnt", moveGnt, eM);
          check("R7 fillGnt", fillGnt, eF);
          @(posedge clk); #1;
          fillReq = 0; moveReq = 0; drainReq = 0;
          es = (s + eF - eM + M) % M;
          ek = (k + eM - eD + M) % M;
          check("R2/R3 srcCount", srcCount, es);
          check("R3/R4 sinkCount", sinkCount, ek);
        end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule